// File: doc/BRIEF.md
# Interrupt Priority Arbiter with Vector Delivery

This block collects interrupt requests from several peripherals and funnels them onto one processor interrupt line. Each peripheral drives its own request line and receives its own acknowledge line. The processor sees one interrupt output and answers it with one acknowledge input. A per-peripheral mask removes a source from consideration. While any unmasked request is pending, the interrupt output is high.

When the processor raises its acknowledge, the arbiter picks one eligible requester and acknowledges it. It also presents that requester's 8-bit vector so the processor can jump to the matching service routine. A mode input picks the ordering. In fixed ordering the lowest index always wins. In rotating ordering the source served most recently drops to the back of the line. The chosen source is frozen for the whole acknowledge phase.

Vectors sit in registers loaded through a valid/ready write port. The port accepts a write on any edge where both valid and ready are high. Ready goes low only while an acknowledge phase is delivering the entry addressed by the write, so a vector can never change under the processor. A write held off this way stays pending until ready returns. Interrupt, mask, mode and acknowledge pins are plain level signals.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, no acknowledge is high, the vector-valid output is low, and entry i of the vector store holds 0x40+i. The rotating search first considers source 0.
- R2: The interrupt output is high in the same cycle exactly when some request bit is 1 and its mask bit is 0. A mask bit of 1 excludes that source.
- R3: On the first clock edge where the processor acknowledge is high after being low, and some source is eligible, one source is latched. After that edge its acknowledge bit is the only one set, the vector output carries its vector, and vector-valid is 1.
- R4: With the mode input at 0 (fixed ordering), the eligible source with the lowest index is latched.
- R5: With the mode input at 1 (rotating ordering), the search starts at the index one above the last completed source and wraps around. The first eligible source found is latched.
- R6: The last-served index is updated only on the edge that ends an acknowledge phase, and it is updated in both modes. An acknowledge with no grant leaves it unchanged.
- R7: While the processor acknowledge stays high, the latched acknowledge and vector stay unchanged whatever the requests, masks or mode do. All of them clear on the first edge where the processor acknowledge is low.
- R8: A source whose mask bit is 1 at the latching edge is never acknowledged.
- R9: If no source is eligible at the rising acknowledge edge, no acknowledge is given and vector-valid stays 0 until the processor acknowledge falls and rises again.
- R10: A write with cfg_valid=1 and cfg_ready=1 at an edge stores cfg_vector into entry cfg_sel. cfg_ready is 0 exactly while vector-valid is 1 and cfg_sel equals the latched source. A write made while cfg_ready is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_rotate | input | 1 | 0 = fixed ordering, 1 = rotating ordering |
| irq_req | input | 4 | Request lines, one per source |
| irq_mask | input | 4 | 1 excludes the source |
| irq_ack | output | 4 | Acknowledge to the latched source |
| cpu_int | output | 1 | Interrupt to the processor |
| cpu_inta | input | 1 | Processor acknowledge |
| vec_out | output | 8 | Vector of the latched source, 0 otherwise |
| vec_valid | output | 1 | vec_out carries a vector |
| cfg_valid | input | 1 | Vector write offered |
| cfg_ready | output | 1 | Vector write accepted |
| cfg_sel | input | 2 | Vector entry to write |
| cfg_vector | input | 8 | Vector value to write |

## Verification
The hardest situation to reach is one where the rotating pointer, the mask and a churning request pattern all interact. A stale pointer then picks a different source than a fresh one would. The stimulus gets there by running long random sequences of complete acknowledge phases with random request, mask and mode values, tracking the last-served index in the bench. During each phase it also changes the requests and tries a write to the latched entry. This exercises the freeze and the write back-pressure together. Directed cases add an acknowledge with nothing eligible, all sources masked, and wrap-around from the top index.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic {
    PRI_FIXED  = 1'b0,
    PRI_ROTATE = 1'b1
  } pri_mode_e;
endpackage

// File: rtl/irq_pick.sv
// Combinational chooser: fixed order or rotating order after last served.
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  eligible,
  input  pri_mode_e     mode,
  input  logic [IW-1:0] last_idx,
  output logic          any,
  output logic [IW-1:0] win_idx
);
  logic [IW-1:0] fixed_idx;
  logic [IW-1:0] rot_idx;

  assign any = |eligible;

  always_comb begin
    fixed_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eligible[i]) fixed_idx = IW'(i);
    end
  end

  always_comb begin
    rot_idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int unsigned j;
      j = (int'(last_idx) + 1 + k) % N;
      if (eligible[j]) rot_idx = IW'(j);
    end
  end

  assign win_idx = (mode == PRI_ROTATE) ? rot_idx : fixed_idx;
endmodule

// File: rtl/irq_vec_store.sv
// Vector register file with one write port and one read port.
module irq_vec_store #(
  parameter int N        = 4,
  parameter int VW       = 8,
  parameter int RST_BASE = 'h40,
  parameter int IW       = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_sel,
  input  logic [VW-1:0] wr_data,
  input  logic [IW-1:0] rd_sel,
  output logic [VW-1:0] rd_data
);
  logic [VW-1:0] entry [N];

  for (genvar g = 0; g < N; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        entry[g] <= VW'(RST_BASE + g);
      else if (wr_en && (wr_sel == IW'(g)))
        entry[g] <= wr_data;
    end
  end

  assign rd_data = entry[rd_sel];
endmodule

// File: rtl/irq_grant_ctl.sv
// Acknowledge-phase controller: latch on rising inta, release on low inta.
module irq_grant_ctl #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inta,
  input  logic          any,
  input  logic [IW-1:0] win_idx,
  output logic          busy,
  output logic [IW-1:0] grant_idx,
  output logic [IW-1:0] last_idx
);
  logic inta_q;
  logic inta_rise;

  assign inta_rise = inta && !inta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inta_q    <= 1'b0;
      busy      <= 1'b0;
      grant_idx <= '0;
      last_idx  <= IW'(N - 1);
    end else begin
      inta_q <= inta;
      if (!busy && inta_rise && any) begin
        busy      <= 1'b1;
        grant_idx <= win_idx;
      end else if (busy && !inta) begin
        busy     <= 1'b0;
        last_idx <= grant_idx;
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N        = 4,
  parameter int VW       = 8,
  parameter int RST_BASE = 'h40,
  localparam int IW      = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_rotate,
  input  logic [N-1:0]  irq_req,
  input  logic [N-1:0]  irq_mask,
  output logic [N-1:0]  irq_ack,
  output logic          cpu_int,
  input  logic          cpu_inta,
  output logic [VW-1:0] vec_out,
  output logic          vec_valid,
  input  logic          cfg_valid,
  output logic          cfg_ready,
  input  logic [IW-1:0] cfg_sel,
  input  logic [VW-1:0] cfg_vector
);
  logic [N-1:0]  eligible;
  logic          any;
  logic [IW-1:0] win_idx;
  logic          busy;
  logic [IW-1:0] grant_idx;
  logic [IW-1:0] last_idx;
  logic [VW-1:0] rd_data;
  pri_mode_e     mode;

  assign mode     = pri_mode_e'(mode_rotate);
  assign eligible = irq_req & ~irq_mask;
  assign cpu_int  = |eligible;

  irq_pick #(.N(N), .IW(IW)) u_pick (
    .eligible (eligible),
    .mode     (mode),
    .last_idx (last_idx),
    .any      (any),
    .win_idx  (win_idx)
  );

  irq_grant_ctl #(.N(N), .IW(IW)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .inta      (cpu_inta),
    .any       (any),
    .win_idx   (win_idx),
    .busy      (busy),
    .grant_idx (grant_idx),
    .last_idx  (last_idx)
  );

  assign cfg_ready = !(busy && (cfg_sel == grant_idx));

  irq_vec_store #(.N(N), .VW(VW), .RST_BASE(RST_BASE), .IW(IW)) u_vec (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_valid && cfg_ready),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_vector),
    .rd_sel  (grant_idx),
    .rd_data (rd_data)
  );

  always_comb begin
    irq_ack = '0;
    if (busy) irq_ack[grant_idx] = 1'b1;
  end

  assign vec_out   = busy ? rd_data : '0;
  assign vec_valid = busy;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int N  = 4,
  parameter int VW = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_rotate,
  input logic [N-1:0]  irq_req,
  input logic [N-1:0]  irq_mask,
  input logic [N-1:0]  irq_ack,
  input logic          cpu_int,
  input logic          cpu_inta,
  input logic [VW-1:0] vec_out,
  input logic          vec_valid,
  input logic          cfg_valid,
  input logic          cfg_ready,
  input logic [IW-1:0] cfg_sel,
  input logic [VW-1:0] cfg_vector
);
  logic [N-1:0] elig_c;
  assign elig_c = irq_req & ~irq_mask;

  a_r3_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack) && ((irq_ack != '0) == vec_valid));

  a_r8_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> ((irq_ack & $past(elig_c)) != '0));

  a_r4_fixed_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vec_valid) && !$past(mode_rotate)) |->
      (irq_ack == ($past(elig_c) & (~$past(elig_c) + 1'b1))));

  a_r7_hold_while_inta: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && cpu_inta) |=> ($stable(irq_ack) && $stable(vec_out)));

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !cpu_inta) |=> !vec_valid);

  a_r10_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ready |-> vec_valid);

  a_r9_no_grant_without_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> !$past(vec_valid) && $past(cpu_inta));
endmodule

bind irq_arbiter irq_arbiter_chk #(.N(N), .VW(VW)) u_chk (.*);

// File: tb/test_irq_arbiter.sv
`timescale 1ns/1ps
module test_irq_arbiter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_rotate;
  logic [3:0] irq_req, irq_mask, irq_ack;
  logic       cpu_int, cpu_inta;
  logic [7:0] vec_out;
  logic       vec_valid;
  logic       cfg_valid, cfg_ready;
  logic [1:0] cfg_sel;
  logic [7:0] cfg_vector;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mvec [4];
  int last = 3;

  always #2 clk = ~clk;

  irq_arbiter i_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .mode_rotate(mode_rotate),
    .irq_req(irq_req), .irq_mask(irq_mask), .irq_ack(irq_ack),
    .cpu_int(cpu_int), .cpu_inta(cpu_inta), .vec_out(vec_out),
    .vec_valid(vec_valid), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_sel(cfg_sel), .cfg_vector(cfg_vector)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic int pick(input logic [3:0] e, input bit rot, input int lst);
    if (e == 4'd0) return -1;
    if (!rot) begin
      for (int i = 0; i < 4; i++) if (e[i]) return i;
    end else begin
      for (int k = 1; k <= 4; k++) if (e[(lst + k) % 4]) return (lst + k) % 4;
    end
    return -1;
  endfunction

  // One full acknowledge phase; winner drops its request afterwards.
  task automatic phase(input logic [3:0] r, input logic [3:0] m, input bit rot, input bit churn);
    int w;
    logic [3:0] e;
    @(negedge clk);
    irq_req = r; irq_mask = m; mode_rotate = rot; cpu_inta = 1'b0;
    #1;
    e = r & ~m;
    check("R2 cpu_int", cpu_int, |e);
    w = pick(e, rot, last);
    @(negedge clk);
    cpu_inta = 1'b1;
    @(negedge clk);
    if (w < 0) begin
      check("R9 no ack", irq_ack, 0);
      check("R9 vec_valid", vec_valid, 0);
    end else begin
      check(rot ? "R5 rotate ack" : "R4 fixed ack", irq_ack, 32'(1 << w));
      check("R3 vector", vec_out, mvec[w]);
      check("R3 vec_valid", vec_valid, 1);
      check("R8 not masked", irq_ack & m, 0);
    end
    if (churn) begin
      irq_req = 4'($urandom);
      irq_mask = 4'($urandom);
      mode_rotate = ~rot;
      if (w >= 0) begin
        cfg_valid = 1'b1; cfg_sel = 2'(w); cfg_vector = 8'($urandom);
        #1;
        check("R10 ready low", cfg_ready, 0);
      end
      @(negedge clk);
      cfg_valid = 1'b0;
      if (w >= 0) begin
        check("R7 hold ack", irq_ack, 32'(1 << w));
        check("R10 blocked write", vec_out, mvec[w]);
      end else begin
        check("R9 stays idle", vec_valid, 0);
      end
    end
    cpu_inta = 1'b0;
    if (w >= 0) irq_req[w] = 1'b0;
    @(negedge clk);
    check("R7 release ack", irq_ack, 0);
    check("R7 release valid", vec_valid, 0);
    if (w >= 0) last = w;
  endtask

  task automatic cfg_write(input int sel, input logic [7:0] v);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_sel = 2'(sel); cfg_vector = v;
    #1;
    check("R10 ready idle", cfg_ready, 1);
    @(negedge clk);
    cfg_valid = 1'b0;
    mvec[sel] = v;
  endtask

  initial begin
    #150000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    rst_n = 1'b0; mode_rotate = 1'b0; irq_req = '0; irq_mask = '0;
    cpu_inta = 1'b0; cfg_valid = 1'b0; cfg_sel = '0; cfg_vector = '0;
    for (int i = 0; i < 4; i++) mvec[i] = 8'(8'h40 + i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ack", irq_ack, 0);
    check("R1 valid", vec_valid, 0);
    check("R1 int", cpu_int, 0);
    // R1 default vectors and first rotating pick at 0
    phase(4'b1111, 4'b0000, 1'b1, 1'b0);
    phase(4'b1000, 4'b0000, 1'b0, 1'b0);
    phase(4'b0100, 4'b0000, 1'b0, 1'b0);
    // R6: pointer now 2; rotating from 3 with wrap
    phase(4'b0011, 4'b0000, 1'b1, 1'b0);
    // R9: nothing eligible, pointer unchanged
    phase(4'b0110, 4'b0110, 1'b1, 1'b1);
    phase(4'b0110, 4'b0000, 1'b1, 1'b0);
    // R8: all masked
    phase(4'b1111, 4'b1111, 1'b0, 1'b0);
    // R4 with mask on low bits
    phase(4'b1111, 4'b0011, 1'b0, 1'b1);
    // R10 writes
    cfg_write(0, 8'hA5);
    cfg_write(3, 8'h3C);
    phase(4'b1001, 4'b0000, 1'b0, 1'b1);
    phase(4'b1000, 4'b0000, 1'b1, 1'b0);
    for (int it = 0; it < 400; it++) begin
      if (($urandom % 8) == 0) cfg_write(int'($urandom % 4), 8'($urandom));
      phase(4'($urandom), 4'($urandom % 16) & 4'($urandom), 1'($urandom), 1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule